// File: doc/BRIEF.md
# Quarter-Chip Readout Word Assembler

This block builds the 48-bit word stream that one quarter of a pixel readout chip hands to its line encoder. Each output word has six bytes, and each byte has its own control-character flag, so that a downstream 8b10b encoder can send comma bytes. Hit words come from a column FIFO over a valid/ready handshake. The block produces exactly one word for every transmit slot that the serial side grants.

The block picks one of four word kinds on every slot, in a fixed priority order:

1. A synchronisation burst, sent after reset or after a forced resync.
2. A frame header, due once per fixed number of time-stamp ticks.
3. A waiting hit word.
4. An idle comma word.

Over each frame the block counts accepted hits and reported collisions. It carries both totals in the next frame header, together with a running frame number.

Top module: `qframe_inserter`

## Requirements
- R1: Every word is 48 bits wide and has a 6-bit per-byte control flag, where flag bit i covers word bits 8i+7..8i. A hit word is the 47-bit input payload with a 0 placed above it at bit 47, and all six flags clear.
- R2: After reset, the block sends SYNC_LEN sync words (default 65536) on consecutive slots. While it does so, `hit_ready_o` stays low, so no hit is consumed. Normal traffic starts on the next slot.
- R3: The sync word and the idle word are identical. Bits 47..8 hold five 0xBC bytes (K28.5), bits 7..0 hold 0xFB (K27.7), and all six flags are set.
- R4: On a slot outside sync, with no frame header due and `hit_valid_i` low, the block sends an idle word and consumes nothing.
- R5: A frame boundary occurs on every FRAME_PERIOD-th `ts_tick_i` pulse (default 2048). The header is sent on the first slot after the boundary that is not in sync, and no header is sent before the boundary.
- R6: The frame header has bit 47 = 1, bits 46..43 = 0, bits 42..37 = collisions of the frame just closed, bits 36..28 = hits of the frame just closed, and bits 27..0 = the frame number. The frame number is 0 after reset and increments at each boundary. All six flags are clear.
- R7: Accepted hits (9 bits) and `coll_i` pulses (6 bits) are counted per frame. Both counters saturate at all-ones. At a boundary they are latched into the header and restart, and an event in the boundary cycle counts toward the new frame.
- R8: A due frame header beats a waiting hit. On that slot `hit_ready_o` is low, and the same hit is accepted on the following slot.
- R9: A `force_sync_i` pulse at any time, even during a running burst, restarts a full SYNC_LEN sync burst.
- R10: `word_o`, `kflag_o` and `word_vld_o` are registered. `word_vld_o` is high exactly in the cycle after a slot cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Transmit slot grant, one word per high cycle |
| ts_tick_i | input | 1 | Time-stamp clock enable, one pulse per tick |
| force_sync_i | input | 1 | Restart the sync burst |
| coll_i | input | 1 | Collision event pulse from column logic |
| hit_valid_i | input | 1 | Hit payload available |
| hit_data_i | input | 47 | Hit payload, bits 46..0 of the hit word |
| hit_ready_o | output | 1 | Hit accepted this cycle when high together with valid |
| word_o | output | 48 | Assembled output word |
| kflag_o | output | 6 | Per-byte control-character flags |
| word_vld_o | output | 1 | Word and flags valid |

## Verification
The assertions check these properties on every cycle:
- Ready stays closed for the whole sync burst.
- A force pulse turns the burst on.
- A burst ends only on a slot.
- Saturated counters stay at full scale inside a frame.
- A boundary always raises a pending header.
- The flags are either all set, with the comma pattern, or all clear.
- A header's spare bits are zero.
- Output validity follows the slot by one cycle.

Some properties only the bench scenarios can show:
- The exact burst length, including a restart during a running burst.
- The placement of the header on the tick count.
- The header totals, both below and at saturation.
- That a hit held back by the header comes out unchanged on the next slot.

// File: rtl/qfi_pkg.sv
package qfi_pkg;

  localparam int unsigned HIT_CNT_W  = 9;
  localparam int unsigned COLL_CNT_W = 6;
  localparam int unsigned FNUM_W     = 28;

  localparam logic [7:0]  K28_5      = 8'hBC;
  localparam logic [7:0]  K27_7      = 8'hFB;
  localparam logic [47:0] COMMA_WORD = {{5{K28_5}}, K27_7};

  typedef enum logic [1:0] {
    SEL_SYNC  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_HIT   = 2'd2,
    SEL_IDLE  = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic                  fmt;
    logic [3:0]            spare;
    logic [COLL_CNT_W-1:0] colls;
    logic [HIT_CNT_W-1:0]  hits;
    logic [FNUM_W-1:0]     fnum;
  } frame_word_t;

  typedef struct packed {
    logic       kind;
    logic [6:0] group_addr;
    logic [4:0] arb_addr;
    logic [4:0] pile_addr;
    logic       lead_sel;
    logic [11:0] lead_coarse;
    logic [4:0] lead_fine;
    logic       trail_sel;
    logic [5:0] trail_coarse;
    logic [4:0] trail_fine;
  } hit_word_t;

endpackage

// File: rtl/qfi_sync_ctrl.sv
module qfi_sync_ctrl #(
  parameter int unsigned SYNC_LEN = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic force_i,
  output logic active_o
);

  localparam int unsigned CW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (force_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (slot_i && act_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

  // R9
  force_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> active_o);

  // R2
  sync_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> ($past(slot_i) && !$past(force_i)));

endmodule

// File: rtl/qfi_frame_stats.sv
module qfi_frame_stats
  import qfi_pkg::*;
#(
  parameter int unsigned FRAME_PERIOD = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ts_tick_i,
  input  logic        hit_acc_i,
  input  logic        coll_i,
  input  logic        frame_sent_i,
  output logic        frame_pend_o,
  output frame_word_t hdr_o
);

  localparam int unsigned TW = (FRAME_PERIOD > 1) ? $clog2(FRAME_PERIOD) : 1;
  localparam logic [TW-1:0] TS_LAST = TW'(FRAME_PERIOD - 1);

  logic [TW-1:0]         ts_q, ts_d;
  logic [HIT_CNT_W-1:0]  hit_q, hit_d, hit_last_q, hit_last_d;
  logic [COLL_CNT_W-1:0] coll_q, coll_d, coll_last_q, coll_last_d;
  logic [FNUM_W-1:0]     fnum_q, fnum_d;
  logic                  pend_q, pend_d;
  logic                  bnd;

  assign bnd = ts_tick_i && (ts_q == TS_LAST);

  always_comb begin
    ts_d        = ts_q;
    hit_d       = hit_q;
    coll_d      = coll_q;
    hit_last_d  = hit_last_q;
    coll_last_d = coll_last_q;
    fnum_d      = fnum_q;
    pend_d      = pend_q;
    if (ts_tick_i) begin
      ts_d = bnd ? '0 : ts_q + 1'b1;
    end
    if (bnd) begin
      hit_last_d  = hit_q;
      coll_last_d = coll_q;
      fnum_d      = fnum_q + 1'b1;
      pend_d      = 1'b1;
      hit_d       = hit_acc_i ? HIT_CNT_W'(1) : '0;
      coll_d      = coll_i ? COLL_CNT_W'(1) : '0;
    end else begin
      if (frame_sent_i) pend_d = 1'b0;
      if (hit_acc_i && (hit_q != '1)) hit_d = hit_q + 1'b1;
      if (coll_i && (coll_q != '1)) coll_d = coll_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q        <= '0;
      hit_q       <= '0;
      coll_q      <= '0;
      hit_last_q  <= '0;
      coll_last_q <= '0;
      fnum_q      <= '0;
      pend_q      <= 1'b0;
    end else begin
      ts_q        <= ts_d;
      hit_q       <= hit_d;
      coll_q      <= coll_d;
      hit_last_q  <= hit_last_d;
      coll_last_q <= coll_last_d;
      fnum_q      <= fnum_d;
      pend_q      <= pend_d;
    end
  end

  assign frame_pend_o = pend_q;
  always_comb begin
    hdr_o       = '0;
    hdr_o.fmt   = 1'b1;
    hdr_o.colls = coll_last_q;
    hdr_o.hits  = hit_last_q;
    hdr_o.fnum  = fnum_q;
  end

  // R7
  hit_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bnd && hit_q == '1) |=> (hit_q == '1));

  // R7
  coll_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bnd && coll_q == '1) |=> (coll_q == '1));

  // R5
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> frame_pend_o);

endmodule

// File: rtl/qfi_word_sel.sv
module qfi_word_sel
  import qfi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slot_i,
  input  logic        sync_act_i,
  input  logic        frame_pend_i,
  input  frame_word_t frame_hdr_i,
  input  logic        hit_valid_i,
  input  logic [46:0] hit_data_i,
  output logic        hit_ready_o,
  output logic        hit_acc_o,
  output logic        frame_sent_o,
  output logic [47:0] word_o,
  output logic [5:0]  kflag_o,
  output logic        word_vld_o
);

  word_sel_e   sel;
  hit_word_t   hw;
  logic [47:0] word_d, word_q;
  logic [5:0]  k_d, k_q;
  logic        vld_q;

  always_comb begin
    if (sync_act_i)        sel = SEL_SYNC;
    else if (frame_pend_i) sel = SEL_FRAME;
    else if (hit_valid_i)  sel = SEL_HIT;
    else                   sel = SEL_IDLE;
  end

  assign hit_ready_o  = slot_i && !sync_act_i && !frame_pend_i;
  assign hit_acc_o    = hit_ready_o && hit_valid_i;
  assign frame_sent_o = slot_i && (sel == SEL_FRAME);

  always_comb begin
    hw      = hit_word_t'({1'b0, hit_data_i});
    hw.kind = 1'b0;
    case (sel)
      SEL_FRAME: begin word_d = frame_hdr_i; k_d = '0; end
      SEL_HIT:   begin word_d = hw;          k_d = '0; end
      default:   begin word_d = COMMA_WORD;  k_d = '1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      k_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= slot_i;
      if (slot_i) begin
        word_q <= word_d;
        k_q    <= k_d;
      end
    end
  end

  assign word_o     = word_q;
  assign kflag_o    = k_q;
  assign word_vld_o = vld_q;

  // R10
  vld_follows_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(slot_i));

  // R3
  kflag_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (kflag_o == 6'h00 || kflag_o == 6'h3F));

  // R3
  comma_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && kflag_o == 6'h3F) |-> (word_o == COMMA_WORD));

  // R6
  frame_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && kflag_o == 6'h00 && word_o[47]) |-> (word_o[46:43] == 4'h0));

endmodule

// File: rtl/qframe_inserter.sv
module qframe_inserter
  import qfi_pkg::*;
#(
  parameter int unsigned SYNC_LEN     = 65536,
  parameter int unsigned FRAME_PERIOD = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slot_i,
  input  logic        ts_tick_i,
  input  logic        force_sync_i,
  input  logic        coll_i,
  input  logic        hit_valid_i,
  input  logic [46:0] hit_data_i,
  output logic        hit_ready_o,
  output logic [47:0] word_o,
  output logic [5:0]  kflag_o,
  output logic        word_vld_o
);

  logic        sync_act;
  logic        frame_pend;
  logic        hit_acc;
  logic        frame_sent;
  frame_word_t hdr;

  qfi_sync_ctrl #(.SYNC_LEN(SYNC_LEN)) sync_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_i   (slot_i),
    .force_i  (force_sync_i),
    .active_o (sync_act)
  );

  qfi_frame_stats #(.FRAME_PERIOD(FRAME_PERIOD)) stats_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ts_tick_i    (ts_tick_i),
    .hit_acc_i    (hit_acc),
    .coll_i       (coll_i),
    .frame_sent_i (frame_sent),
    .frame_pend_o (frame_pend),
    .hdr_o        (hdr)
  );

  qfi_word_sel sel_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_i       (slot_i),
    .sync_act_i   (sync_act),
    .frame_pend_i (frame_pend),
    .frame_hdr_i  (hdr),
    .hit_valid_i  (hit_valid_i),
    .hit_data_i   (hit_data_i),
    .hit_ready_o  (hit_ready_o),
    .hit_acc_o    (hit_acc),
    .frame_sent_o (frame_sent),
    .word_o       (word_o),
    .kflag_o      (kflag_o),
    .word_vld_o   (word_vld_o)
  );

  // R2
  sync_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_act |-> !hit_ready_o);

  // R8
  frame_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && frame_pend && !sync_act) |=> (word_o[47] && kflag_o == 6'h00));

endmodule

// File: tb/qframe_inserter_tb_top.sv
module qframe_inserter_tb_top;

  localparam int unsigned SYNC_LEN     = 8;
  localparam int unsigned FRAME_PERIOD = 16;
  localparam logic [47:0] COMMA = 48'hBCBC_BCBC_BCFB;

  // bit 48 = valid, bit 47 = collision pulse, bits 46..0 = payload
  localparam logic [48:0] VEC [0:7] = '{
    {1'b1, 1'b0, 47'h1234_5678_9ABC},
    {1'b0, 1'b1, 47'h0000_0000_0000},
    {1'b1, 1'b1, 47'h7FFF_FFFF_FFFF},
    {1'b1, 1'b0, 47'h0000_0000_0001},
    {1'b0, 1'b0, 47'h5555_5555_5555},
    {1'b1, 1'b1, 47'h2AAA_AAAA_AAAA},
    {1'b0, 1'b0, 47'h0000_0000_0000},
    {1'b1, 1'b0, 47'h4000_0000_0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        slot_i, ts_tick_i, force_sync_i, coll_i, hit_valid_i;
  logic [46:0] hit_data_i;
  logic        hit_ready_o;
  logic [47:0] word_o;
  logic [5:0]  kflag_o;
  logic        word_vld_o;

  int checks = 0;
  int errors = 0;
  int hit_exp, coll_exp;

  always #10 clk_i = ~clk_i;

  qframe_inserter #(.SYNC_LEN(SYNC_LEN), .FRAME_PERIOD(FRAME_PERIOD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_i), .ts_tick_i(ts_tick_i),
    .force_sync_i(force_sync_i), .coll_i(coll_i), .hit_valid_i(hit_valid_i),
    .hit_data_i(hit_data_i), .hit_ready_o(hit_ready_o), .word_o(word_o),
    .kflag_o(kflag_o), .word_vld_o(word_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_slot(input logic v, input logic [46:0] d, input logic c,
                         output logic rdy, output logic [47:0] w, output logic [5:0] k,
                         output logic vld);
    slot_i = 1'b1; hit_valid_i = v; hit_data_i = d; coll_i = c;
    #1 rdy = hit_ready_o;
    @(posedge clk_i);
    @(negedge clk_i);
    w = word_o; k = kflag_o; vld = word_vld_o;
    slot_i = 1'b0; hit_valid_i = 1'b0; coll_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ts_tick_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      ts_tick_i = 1'b0;
    end
  endtask

  task automatic pulse_force();
    force_sync_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    force_sync_i = 1'b0;
  endtask

  task automatic expect_sync(input int n, input string req);
    logic r, vl; logic [47:0] w; logic [5:0] k;
    for (int i = 0; i < n; i++) begin
      do_slot(1'b1, 47'h0123_4567_89AB, 1'b0, r, w, k, vl);
      chk(!r, req, {63'd0, r}, 64'd0);
      chk(w == COMMA && k == 6'h3F, "R3", {10'd0, k, w}, {10'd0, 6'h3F, COMMA});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic r, vl; logic [47:0] w; logic [5:0] k;
    logic [47:0] fexp;
    rst_ni = 1'b0; slot_i = 1'b0; ts_tick_i = 1'b0; force_sync_i = 1'b0;
    coll_i = 1'b0; hit_valid_i = 1'b0; hit_data_i = '0;
    hit_exp = 0; coll_exp = 0;
    repeat (3) @(negedge clk_i);
    // reset state (R10, R2)
    chk(word_vld_o == 1'b0, "R10 reset", {63'd0, word_vld_o}, 64'd0);
    chk(hit_ready_o == 1'b0, "R2 reset", {63'd0, hit_ready_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: exactly SYNC_LEN sync words, then the first hit passes
    expect_sync(SYNC_LEN, "R2");
    do_slot(1'b1, 47'h0ABC_DEF0_1234, 1'b0, r, w, k, vl);
    chk(r, "R2 end of sync", {63'd0, r}, 64'd1);
    chk(w == {1'b0, 47'h0ABC_DEF0_1234} && k == 0, "R1", {10'd0, k, w}, {16'd0, 1'b0, 47'h0ABC_DEF0_1234});
    hit_exp++;
    // R10: no slot, no valid
    @(negedge clk_i);
    chk(word_vld_o == 1'b0, "R10 idle cycle", {63'd0, word_vld_o}, 64'd0);

    // vector table: hits and idles (R1, R4)
    for (int i = 0; i < 8; i++) begin
      do_slot(VEC[i][48], VEC[i][46:0], VEC[i][47], r, w, k, vl);
      chk(r && vl, "R10 slot", {62'd0, r, vl}, 64'd3);
      if (VEC[i][48]) begin
        chk(w == {1'b0, VEC[i][46:0]} && k == 0, "R1", {10'd0, k, w}, {16'd0, 1'b0, VEC[i][46:0]});
        hit_exp++;
      end else begin
        chk(w == COMMA && k == 6'h3F, "R4", {10'd0, k, w}, {10'd0, 6'h3F, COMMA});
      end
      if (VEC[i][47]) coll_exp++;
    end

    // R5: no header one tick early
    ticks(FRAME_PERIOD - 1);
    do_slot(1'b1, 47'h0000_1111_2222, 1'b0, r, w, k, vl);
    chk(r && w == {1'b0, 47'h0000_1111_2222}, "R5 no early frame", {15'd0, r, w}, {16'd1, 1'b0, 47'h0000_1111_2222});
    hit_exp++;
    ticks(1);

    // R6 / R8: header beats waiting hit, hit held
    do_slot(1'b1, 47'h3333_4444_5555, 1'b0, r, w, k, vl);
    chk(!r, "R8 ready low", {63'd0, r}, 64'd0);
    fexp = {1'b1, 4'h0, 6'(coll_exp), 9'(hit_exp), 28'd1};
    chk(w == fexp && k == 0, "R6 frame 1", {10'd0, k, w}, {16'd0, fexp});
    hit_exp = 0; coll_exp = 0;
    do_slot(1'b1, 47'h3333_4444_5555, 1'b0, r, w, k, vl);
    chk(r && w == {1'b0, 47'h3333_4444_5555}, "R8 held hit", {15'd0, r, w}, {16'd1, 1'b0, 47'h3333_4444_5555});

    // R7: saturation
    for (int i = 0; i < 600; i++) begin
      do_slot(1'b1, 47'(i), 1'b1, r, w, k, vl);
    end
    ticks(FRAME_PERIOD);
    do_slot(1'b0, 47'h0, 1'b0, r, w, k, vl);
    fexp = {1'b1, 4'h0, 6'h3F, 9'h1FF, 28'd2};
    chk(w == fexp && k == 0, "R7 saturated frame 2", {10'd0, k, w}, {16'd0, fexp});
    do_slot(1'b0, 47'h0, 1'b0, r, w, k, vl);
    chk(r && w == COMMA, "R4 after frame", {15'd0, r, w}, {16'd1, COMMA});

    // R9: force during normal traffic, then again mid-burst
    pulse_force();
    expect_sync(4, "R9");
    pulse_force();
    expect_sync(SYNC_LEN, "R9 restart");
    do_slot(1'b1, 47'h6666_7777_0000, 1'b0, r, w, k, vl);
    chk(r && w == {1'b0, 47'h6666_7777_0000}, "R9 resume", {15'd0, r, w}, {16'd1, 1'b0, 47'h6666_7777_0000});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule